// File: doc/BRIEF.md
# Load-Reserved Store-Conditional Monitor

This block places a shared word memory behind several requesting cores and gives them reserve-then-conditionally-store semantics. Software builds atomic read-modify-write sequences from it: a core reads a word while taking a reservation on it, computes a new value, and then issues a conditional store. The store commits only if no other store has touched that word since the reservation was taken. Retrying after a failure is left to software.

Each core offers one request at a time: a valid bit, an operation, a word address and write data. A fixed-priority arbiter accepts one request per cycle. The lowest-numbered requesting core wins, and the others hold their request until they are granted. Every core owns one reservation slot. The slot is a two-state machine with states RSV_EMPTY and RSV_HELD and a stored word index, and it has four named transitions:
- TAKE: RSV_EMPTY to RSV_HELD, on the core's own load-reserve.
- RETARGET: RSV_HELD to RSV_HELD with a new index, on a further load-reserve.
- CONSUME: RSV_HELD to RSV_EMPTY, on the core's own conditional store, whether it succeeds or not.
- SNOOP_KILL: RSV_HELD to RSV_EMPTY, when any core commits a store to the held word.

Responses are registered. A response arrives one cycle after the request is accepted, on a shared data bus, with a per-core strobe.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, no response strobe is high, every memory word reads as zero and every reservation slot is empty, so a conditional store issued first fails.
- R2: In each cycle exactly the lowest-indexed core with `req_valid` high is granted on `req_grant`, in the same cycle. A core that is not granted is not serviced, and its request stays pending.
- R3: The operation codes are 0 load, 1 store, 2 load-reserve and 3 store-conditional. A load and a load-reserve both return the addressed word. A load-reserve also records the word index in the core's reservation slot.
- R4: A load-reserve replaces any reservation the core already holds, so a later conditional store to the earlier word fails.
- R5: A conditional store whose core holds a reservation on the same word writes the data, empties the slot and reports `rsp_sc_ok` = 1.
- R6: A conditional store without a matching reservation, including one whose address differs from the reserved word, leaves memory unchanged, reports `rsp_sc_ok` = 0 and empties the core's slot.
- R7: Every committed write, whether a plain store or a successful conditional store from any core including the holder itself, empties every slot reserved on that word. A failed conditional store empties no other core's slot.
- R8: One cycle after a grant, `rsp_valid` equals that grant. `rsp_rdata` carries the word as it stood before the access, for every operation. `rsp_sc_ok` is 0 for every operation other than a conditional store. With no grant, `rsp_valid` is all zero.
- R9: Only the low log2(MEM_WORDS) address bits select a word. Higher bits take no part in memory access or in reservation matching.
- R10: A plain store always writes its data to the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-core request present |
| req_op | input | NCORE x 2 | Per-core operation code |
| req_addr | input | NCORE x 32 | Per-core word address |
| req_wdata | input | NCORE x 32 | Per-core write data |
| req_grant | output | NCORE | One-hot acceptance this cycle |
| rsp_valid | output | NCORE | One-hot response strobe |
| rsp_rdata | output | 32 | Word before the access |
| rsp_sc_ok | output | 1 | Conditional store committed |

## Verification
`req_grant` is combinational. The bench checks it one time step after driving the inputs on the falling edge, before the accepting rising edge. Every response value, which is the strobe, the read word and the success flag, is registered once and is therefore due exactly one rising edge after acceptance. The bench samples it on the following falling edge and compares it against the bench's own memory and reservation model, which the bench updated when it made that request. The effects of stores and of failed conditional stores are observed through later loads and conditional stores, each checked in its own response cycle.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_LOAD       = 2'd0,
        OP_STORE      = 2'd1,
        OP_LOAD_RSV   = 2'd2,
        OP_STORE_COND = 2'd3
    } lrsc_op_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/lrsc_prio_arb.sv
module lrsc_prio_arb #(
    parameter int N    = 4,
    localparam int W_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic [W_W-1:0] winner,
    output logic           any
);

    always_comb begin
        grant  = '0;
        winner = '0;
        any    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                winner   = W_W'(i);
                any      = 1'b1;
            end
        end
    end

    // R2: a granted core never has a requesting core below it
    for (genvar g = 0; g < N; g++) begin : g_chk
        localparam logic [N-1:0] LOWER = (N'(1) << g) - N'(1);
        a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |-> ((req & LOWER) == '0) && req[g]);
    end

    // R2: some request always yields a grant
    a_r2_no_starve_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (grant != '0));

endmodule

// File: rtl/lrsc_word_mem.sv
module lrsc_word_mem #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [WORDS];

    assign rdata = cells[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    // R10: a write lands in the addressed word
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cells[$past(idx)] == $past(wdata));

endmodule

// File: rtl/lrsc_rsv_slot.sv
module lrsc_rsv_slot
    import lrsc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lr_take,
    input  logic             sc_take,
    input  logic             wr_commit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] req_idx,
    output logic             held,
    output logic             match
);

    rsv_state_e       state, nxt_state;
    logic [IDX_W-1:0] rsv_idx, nxt_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RSV_EMPTY;
            rsv_idx <= '0;
        end else begin
            state   <= nxt_state;
            rsv_idx <= nxt_idx;
        end
    end

    // transitions: TAKE, RETARGET, CONSUME, SNOOP_KILL
    always_comb begin
        nxt_state = state;
        nxt_idx   = rsv_idx;
        unique case (state)
            RSV_EMPTY: begin
                if (lr_take) begin
                    nxt_state = RSV_HELD;
                    nxt_idx   = req_idx;
                end
            end
            RSV_HELD: begin
                if (lr_take) begin
                    nxt_idx = req_idx;
                end else if (sc_take) begin
                    nxt_state = RSV_EMPTY;
                end else if (wr_commit && (wr_idx == rsv_idx)) begin
                    nxt_state = RSV_EMPTY;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        held  = (state == RSV_HELD);
        match = held && (rsv_idx == req_idx);
    end

    a_r3_lr_records: assert property (@(posedge clk) disable iff (!rst_n)
        lr_take |=> held && (rsv_idx == $past(req_idx)));

    a_r6_sc_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_take && !lr_take) |=> !held);

    a_r7_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && held && (wr_idx == rsv_idx) && !lr_take) |=> !held);

    a_r1_reset_empty: assert property (@(posedge clk)
        $past(!rst_n) |-> !held);

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int NCORE     = 4,
    parameter int MEM_WORDS = 16,
    localparam int IDX_W    = $clog2(MEM_WORDS),
    localparam int CI_W     = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORE-1:0]             req_valid,
    input  logic [NCORE-1:0][1:0]        req_op,
    input  logic [NCORE-1:0][WORD_W-1:0] req_addr,
    input  logic [NCORE-1:0][WORD_W-1:0] req_wdata,
    output logic [NCORE-1:0]             req_grant,
    output logic [NCORE-1:0]             rsp_valid,
    output logic [WORD_W-1:0]            rsp_rdata,
    output logic                         rsp_sc_ok
);

    logic [NCORE-1:0]  grant;
    logic [CI_W-1:0]   win;
    logic              any_grant;
    lrsc_op_e          win_op;
    logic [IDX_W-1:0]  win_idx;
    logic [WORD_W-1:0] win_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic [NCORE-1:0]  slot_held;
    logic [NCORE-1:0]  slot_match;
    logic              sc_pass;
    logic              commit;

    lrsc_prio_arb #(.N(NCORE)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_valid),
        .grant  (grant),
        .winner (win),
        .any    (any_grant)
    );

    assign req_grant = grant;

    always_comb begin
        win_op    = lrsc_op_e'(req_op[win]);
        win_idx   = req_addr[win][IDX_W-1:0];
        win_wdata = req_wdata[win];
        sc_pass   = slot_match[win];
        commit    = 1'b0;
        if (any_grant) begin
            unique case (win_op)
                OP_STORE:      commit = 1'b1;
                OP_STORE_COND: commit = sc_pass;
                OP_LOAD,
                OP_LOAD_RSV:   commit = 1'b0;
            endcase
        end
    end

    lrsc_word_mem #(.WORDS(MEM_WORDS), .DATA_W(WORD_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .idx   (win_idx),
        .wdata (win_wdata),
        .rdata (mem_rdata)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_slot
        lrsc_rsv_slot #(.IDX_W(IDX_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .lr_take   (grant[c] && (win_op == OP_LOAD_RSV)),
            .sc_take   (grant[c] && (win_op == OP_STORE_COND)),
            .wr_commit (commit),
            .wr_idx    (win_idx),
            .req_idx   (win_idx),
            .held      (slot_held[c]),
            .match     (slot_match[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= grant;
            rsp_rdata <= mem_rdata;
            rsp_sc_ok <= any_grant && (win_op == OP_STORE_COND) && sc_pass;
        end
    end

    a_r8_rsp_tracks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        any_grant |=> rsp_valid == $past(grant));

    a_r8_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !any_grant |=> rsp_valid == '0);

    a_r8_ok_only_for_sc: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok |-> $past(any_grant && win_op == OP_STORE_COND));

    a_r5_ok_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && win_op == OP_STORE_COND && !slot_held[win]) |=> !rsp_sc_ok);

endmodule

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WORDS      = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         req_valid = '0;
    logic [N-1:0][1:0]    req_op = '0;
    logic [N-1:0][31:0]   req_addr = '0;
    logic [N-1:0][31:0]   req_wdata = '0;
    logic [N-1:0]         req_grant;
    logic [N-1:0]         rsp_valid;
    logic [31:0]          rsp_rdata;
    logic                 rsp_sc_ok;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] ref_mem [WORDS];
    logic        ref_rv  [N];
    logic [3:0]  ref_ra  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsc_monitor #(.NCORE(N), .MEM_WORDS(WORDS)) i_lrsc_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_grant (req_grant),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_sc_ok (rsp_sc_ok)
    );

    function automatic logic [N-1:0] exp_grant(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
        return '0;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request cycle; starts and ends at a falling edge.
    task automatic step(input logic [N-1:0] v, input logic [N-1:0][1:0] op,
                        input logic [N-1:0][31:0] a, input logic [N-1:0][31:0] d,
                        input string tag);
        logic [N-1:0] g;
        int           w;
        logic [3:0]   ix;
        logic [31:0]  e_rd;
        logic         e_ok;
        req_valid = v; req_op = op; req_addr = a; req_wdata = d;
        g = exp_grant(v);
        #1;
        check(32'(req_grant), 32'(g), {tag, " R2 grant"});
        e_rd = '0; e_ok = 1'b0;
        if (g != '0) begin
            w = 0;
            for (int i = N-1; i >= 0; i--) if (g[i]) w = i;
            ix   = a[w][3:0];
            e_rd = ref_mem[ix];
            unique case (op[w])
                2'd0: ;
                2'd1: begin
                    ref_mem[ix] = d[w];
                    for (int i = 0; i < N; i++) if (ref_rv[i] && ref_ra[i] == ix) ref_rv[i] = 1'b0;
                end
                2'd2: begin ref_rv[w] = 1'b1; ref_ra[w] = ix; end
                2'd3: begin
                    if (ref_rv[w] && ref_ra[w] == ix) begin
                        e_ok = 1'b1;
                        ref_mem[ix] = d[w];
                        for (int i = 0; i < N; i++) if (ref_rv[i] && ref_ra[i] == ix) ref_rv[i] = 1'b0;
                    end else begin
                        ref_rv[w] = 1'b0;
                    end
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        check(32'(rsp_valid), 32'(g), {tag, " R8 strobe"});
        if (g != '0) begin
            check(rsp_rdata, e_rd, {tag, " R3 R8 rdata"});
            check(32'(rsp_sc_ok), 32'(e_ok), {tag, " R5 R6 sc_ok"});
        end
    endtask

    task automatic one(input int c, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] d, input string tag);
        logic [N-1:0]       v = '0;
        logic [N-1:0][1:0]  o = '0;
        logic [N-1:0][31:0] aa = '0;
        logic [N-1:0][31:0] dd = '0;
        v[c] = 1'b1; o[c] = op; aa[c] = a; dd[c] = d;
        step(v, o, aa, dd, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0]       v;
        logic [N-1:0][1:0]  o;
        logic [N-1:0][31:0] aa;
        logic [N-1:0][31:0] dd;
        void'($urandom(32'd4711));
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        for (int i = 0; i < N; i++) begin ref_rv[i] = 1'b0; ref_ra[i] = '0; end

        repeat (3) @(negedge clk);
        check(32'(rsp_valid), 32'd0, "R1 strobe in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: memory zero, first conditional store fails
        one(1, 2'd0, 32'd5, 32'd0, "R1 load after reset");
        one(2, 2'd3, 32'd6, 32'hDEAD_0001, "R1 sc after reset");
        one(0, 2'd0, 32'd6, 32'd0, "R1 R6 memory unchanged");

        // R5: reserve then conditional store succeeds
        one(0, 2'd1, 32'd3, 32'h1111_0000, "R10 store");
        one(0, 2'd2, 32'd3, 32'd0, "R3 load-reserve");
        one(0, 2'd3, 32'd3, 32'h1111_0001, "R5 sc success");
        one(0, 2'd3, 32'd3, 32'h1111_0002, "R5 slot emptied after success");
        one(1, 2'd0, 32'd3, 32'd0, "R5 value kept");

        // R7: another core's store kills the reservation
        one(1, 2'd2, 32'd4, 32'd0, "R7 reserve");
        one(2, 2'd1, 32'd4, 32'h2222_0000, "R7 foreign store");
        one(1, 2'd3, 32'd4, 32'h2222_0001, "R7 sc after foreign store");

        // R7: own plain store also kills it
        one(3, 2'd2, 32'd7, 32'd0, "R7 reserve own");
        one(3, 2'd1, 32'd7, 32'h3333_0000, "R7 own store");
        one(3, 2'd3, 32'd7, 32'h3333_0001, "R7 sc after own store");

        // R7: failed sc from another core does not kill
        one(0, 2'd2, 32'd8, 32'd0, "R7 reserve");
        one(1, 2'd3, 32'd8, 32'h4444_0000, "R7 foreign failed sc");
        one(0, 2'd3, 32'd8, 32'h4444_0001, "R7 sc survives failed sc");

        // R6: mismatched address fails and empties the slot
        one(2, 2'd2, 32'd9, 32'd0, "R6 reserve");
        one(2, 2'd3, 32'd10, 32'h5555_0000, "R6 mismatch sc");
        one(2, 2'd3, 32'd9, 32'h5555_0001, "R6 slot emptied by failure");
        one(2, 2'd0, 32'd10, 32'd0, "R6 memory unchanged");

        // R4: new reservation replaces the old one
        one(1, 2'd2, 32'd11, 32'd0, "R4 reserve first");
        one(1, 2'd2, 32'd12, 32'd0, "R4 reserve second");
        one(1, 2'd3, 32'd11, 32'h6666_0000, "R4 old word fails");

        // R9: upper address bits ignored
        one(0, 2'd2, 32'hABC0_0012, 32'd0, "R9 reserve with upper bits");
        one(0, 2'd3, 32'd2, 32'h7777_0000, "R9 sc plain index");
        one(3, 2'd0, 32'hFFFF_FFF2, 32'd0, "R9 load aliased");

        // R2: contention, core0 store and core1 sc together
        one(1, 2'd2, 32'd13, 32'd0, "R2 reserve");
        v = 4'b0011; o = '0; aa = '0; dd = '0;
        o[0] = 2'd1; aa[0] = 32'd13; dd[0] = 32'h8888_0000;
        o[1] = 2'd3; aa[1] = 32'd13; dd[1] = 32'h8888_0001;
        step(v, o, aa, dd, "R2 core0 first");
        v = 4'b0010;
        step(v, o, aa, dd, "R2 core1 waits then fails");
        v = 4'b1100; o[2] = 2'd0; o[3] = 2'd1; aa[2] = 32'd13; aa[3] = 32'd14;
        step(v, o, aa, dd, "R2 core2 over core3");

        // idle cycle
        step('0, '0, '0, '0, "R8 idle");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            for (int c = 0; c < N; c++) begin
                v[c]  = 1'($urandom_range(1, 0));
                o[c]  = 2'($urandom_range(3, 0));
                aa[c] = {($urandom_range(3, 0) == 0) ? 28'($urandom) : 28'd0,
                         4'($urandom_range(3, 0))};
                dd[c] = $urandom;
            end
            step(v, o, aa, dd, "R2 R3 R5 R6 R7 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule